// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a bank of SDRAM rows out of power-up. After a `start` pulse it waits a stabilization period, then walks the rows in ascending index order. For each populated row it issues a fixed series of mode commands, each followed by a wait counted in microsecond ticks. The row closes with a pattern write and a read-back at the row's base. Once the last row is done it switches refresh on, and one cycle later it raises the completion flag.

A row counts as populated when its cumulative boundary value is strictly greater than the boundary of the row below it; row 0 is compared against zero. The command code output holds the current mode select. `cmd_strobe` marks the one cycle in which a command is issued to the selected row. Waits are counted on `tick_us`, a one-cycle pulse supplied from outside once per microsecond. The boundary inputs must stay stable while a sequence runs.

States: IDLE (after reset), SETTLE (stabilization wait), NOP_ISSUE/NOP_HOLD, PRE_ISSUE/PRE_HOLD, CBR_ISSUE/CBR_HOLD (looped eight times), MRS_ISSUE/MRS_HOLD, NORM_ISSUE/NORM_HOLD, PROBE_WR, PROBE_RD, REF_ON, READY. The transitions are:
- IDLE or READY goes to SETTLE on `start`.
- SETTLE goes, when its wait expires, to NOP_ISSUE of the first populated row, or to REF_ON if there is none.
- Each ISSUE state goes to its HOLD state. Each HOLD state goes to the next ISSUE state when its wait expires.
- CBR_HOLD returns to CBR_ISSUE until eight refreshes have been issued, then goes to MRS_ISSUE.
- NORM_HOLD goes to PROBE_WR, and PROBE_WR goes to PROBE_RD.
- PROBE_RD goes to NOP_ISSUE of the next populated row above, or to REF_ON.
- REF_ON goes to READY.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After reset the outputs are `cmd_code`=1 (NOP), `refresh_mode`=0, and `cmd_strobe`, `row_sel`, `row_base`, `mrs_addr`, `probe_wr`, `probe_rd`, `probe_data` and `init_done` all 0.
- R2: Command codes on `cmd_code` are NOP=1, precharge-all=2, mode-register-set=3, CBR auto-refresh=6 and normal=7. Code 0 (self-refresh) is never driven.
- R3: After `start` is accepted, exactly 200 ticks are consumed before the first command strobe, or before refresh is enabled if no row is populated.
- R4: Row i (bits [8i+7:8i] of `row_bound`) is initialized only when its value, taken unsigned, is greater than row i-1's value; row 0 is compared against 0. Rows are visited in ascending order. During a row, `row_sel` is one-hot with bit i set and `row_base` equals row i-1's value (0 for row 0).
- R5: Per row, the command strobes follow this order, with the given number of ticks consumed after each one: NOP, 200; precharge-all, 1; CBR ×8, 1 each; mode-register-set, 2; normal, 1.
- R6: On the mode-register-set strobe, `mrs_addr` equals 0x1D0.
- R7: The tick wait after the normal command is followed by a single-cycle `probe_wr` with `probe_data`=0x55AA55AA and `cmd_code`=7. `probe_rd` follows in the next cycle. The next row's NOP strobe, or the enabling of refresh, comes in the cycle after that.
- R8: `refresh_mode` becomes 1 in the cycle after the final probe read, or after the stabilization wait. `init_done` rises one cycle later. Both hold until the next accepted start.
- R9: A `start` pulse while a sequence is running has no effect on the command stream.
- R10: With no populated row, the block still enables refresh and asserts `init_done`.
- R11: `start` in the completed state begins a new sequence. In the next cycle `init_done` and `refresh_mode` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when idle or complete |
| tick_us | input | 1 | One-cycle microsecond tick |
| row_bound | input | ROWS*BW | Cumulative boundary per row, row i at [i*BW +: BW] |
| cmd_code | output | 3 | Current mode select code |
| cmd_strobe | output | 1 | Command issued this cycle |
| row_sel | output | ROWS | One-hot select of the row being initialized |
| row_base | output | BW | Base (previous boundary) of the selected row |
| mrs_addr | output | AW | Mode value during mode-register-set |
| probe_wr | output | 1 | Dummy pattern write strobe |
| probe_rd | output | 1 | Dummy read strobe |
| probe_data | output | DW | Pattern driven with the write strobe |
| refresh_mode | output | 3 | Refresh mode, 1 once enabled |
| init_done | output | 1 | Initialization complete |

## Verification
Several properties are checked on every cycle: the row select stays one-hot or idle, and each strobe carries a row. The mode value appears with every mode-register-set strobe, and every probe write carries the pattern and is followed by its read. Each issue lasts exactly one cycle, and completion only ever follows an enabled refresh. Other behaviour shows only over a whole scenario: which rows get visited for a given boundary set, the exact number of ticks consumed between events, the count of eight refreshes, the immunity to `start` pulses in mid-sequence, and restart from the completed state. The bench compares these against an event stream it predicts for each boundary set, including the empty, sparse, non-monotonic and saturated cases.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_SELF_REF  = 3'd0,
        CMD_NOP       = 3'd1,
        CMD_PRECHARGE = 3'd2,
        CMD_MODE_SET  = 3'd3,
        CMD_AUTO_REF  = 3'd6,
        CMD_NORMAL    = 3'd7
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_NOP_ISSUE,
        ST_NOP_HOLD,
        ST_PRE_ISSUE,
        ST_PRE_HOLD,
        ST_CBR_ISSUE,
        ST_CBR_HOLD,
        ST_MRS_ISSUE,
        ST_MRS_HOLD,
        ST_NORM_ISSUE,
        ST_NORM_HOLD,
        ST_PROBE_WR,
        ST_PROBE_RD,
        ST_REF_ON,
        ST_READY
    } seq_state_e;

    localparam logic [2:0] REF_MODE_OFF = 3'd0;
    localparam logic [2:0] REF_MODE_ON  = 3'd1;

endpackage

// File: rtl/sdram_us_timer.sv
module sdram_us_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Expires on the tick that consumes the last outstanding microsecond.
    assign expire = !load && tick && (remain == TW'(1));
endmodule

// File: rtl/sdram_burst_count.sv
module sdram_burst_count #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_row_scan.sv
module sdram_row_scan #(
    parameter int ROWS = 4,
    parameter int BW   = 8,
    parameter int IW   = 2
) (
    input  logic [ROWS*BW-1:0] bounds,
    input  logic [IW:0]        scan_from,
    input  logic [IW-1:0]      cur_idx,
    output logic               found,
    output logic [IW-1:0]      found_idx,
    output logic [BW-1:0]      cur_base
);
    logic [ROWS-1:0] populated;
    logic [BW-1:0]   lower [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        if (g == 0) begin : g_first
            assign lower[g] = '0;
        end else begin : g_rest
            assign lower[g] = bounds[(g-1)*BW +: BW];
        end
        assign populated[g] = bounds[g*BW +: BW] > lower[g];
    end

    // Lowest populated row at or above scan_from.
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (populated[i] && (i >= int'(scan_from))) begin
                found     = 1'b1;
                found_idx = IW'(i);
            end
        end
    end

    assign cur_base = lower[cur_idx];
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_seq_pkg::*;
#(
    parameter int          ROWS          = 4,
    parameter int          BW            = 8,
    parameter int          AW            = 13,
    parameter int          DW            = 32,
    parameter int          SETTLE_US     = 200,
    parameter int          NOP_US        = 200,
    parameter int          PRE_US        = 1,
    parameter int          CBR_US        = 1,
    parameter int          MRS_US        = 2,
    parameter int          NORM_US       = 1,
    parameter int          CBR_COUNT     = 8,
    parameter logic [AW-1:0] MRS_VALUE   = 13'h1D0,
    parameter logic [DW-1:0] PROBE_PATTERN = 32'h55AA55AA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tick_us,
    input  logic [ROWS*BW-1:0] row_bound,
    output logic [2:0]         cmd_code,
    output logic               cmd_strobe,
    output logic [ROWS-1:0]    row_sel,
    output logic [BW-1:0]      row_base,
    output logic [AW-1:0]      mrs_addr,
    output logic               probe_wr,
    output logic               probe_rd,
    output logic [DW-1:0]      probe_data,
    output logic [2:0]         refresh_mode,
    output logic               init_done
);
    localparam int MAX_A    = (SETTLE_US > NOP_US) ? SETTLE_US : NOP_US;
    localparam int MAX_B    = (PRE_US > CBR_US) ? PRE_US : CBR_US;
    localparam int MAX_C    = (MRS_US > NORM_US) ? MRS_US : NORM_US;
    localparam int MAX_AB   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_WAIT = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int TW       = $clog2(MAX_WAIT + 1);
    localparam int CW       = $clog2(CBR_COUNT + 1);
    localparam int IW       = (ROWS > 1) ? $clog2(ROWS) : 1;

    seq_state_e      state, state_nx;
    logic [IW-1:0]   cur_row;
    logic            t_load, t_expire;
    logic [TW-1:0]   t_val;
    logic [CW-1:0]   cbr_issued;
    logic            cbr_all;
    logic [IW:0]     scan_from;
    logic            scan_found;
    logic [IW-1:0]   scan_idx;
    logic [BW-1:0]   base_of_cur;
    logic            in_row;
    logic            accept;

    assign accept  = start && (state == ST_IDLE || state == ST_READY);
    assign cbr_all = (cbr_issued == CW'(CBR_COUNT));

    assign scan_from = (state == ST_PROBE_RD) ? ({1'b0, cur_row} + 1'b1) : '0;

    sdram_row_scan #(.ROWS(ROWS), .BW(BW), .IW(IW)) u_scan (
        .bounds    (row_bound),
        .scan_from (scan_from),
        .cur_idx   (cur_row),
        .found     (scan_found),
        .found_idx (scan_idx),
        .cur_base  (base_of_cur)
    );

    // Wait length loaded at each issue point.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE, ST_READY: begin
                t_load = start;
                t_val  = TW'(SETTLE_US);
            end
            ST_NOP_ISSUE:  begin t_load = 1'b1; t_val = TW'(NOP_US);  end
            ST_PRE_ISSUE:  begin t_load = 1'b1; t_val = TW'(PRE_US);  end
            ST_CBR_ISSUE:  begin t_load = 1'b1; t_val = TW'(CBR_US);  end
            ST_MRS_ISSUE:  begin t_load = 1'b1; t_val = TW'(MRS_US);  end
            ST_NORM_ISSUE: begin t_load = 1'b1; t_val = TW'(NORM_US); end
            default: ;
        endcase
    end

    sdram_us_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .tick     (tick_us),
        .expire   (t_expire)
    );

    sdram_burst_count #(.CW(CW)) u_cbr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_PRE_ISSUE),
        .inc   (state == ST_CBR_ISSUE),
        .count (cbr_issued)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_READY: if (accept) state_nx = ST_SETTLE;
            ST_SETTLE:
                if (t_expire) state_nx = scan_found ? ST_NOP_ISSUE : ST_REF_ON;
            ST_NOP_ISSUE:  state_nx = ST_NOP_HOLD;
            ST_NOP_HOLD:   if (t_expire) state_nx = ST_PRE_ISSUE;
            ST_PRE_ISSUE:  state_nx = ST_PRE_HOLD;
            ST_PRE_HOLD:   if (t_expire) state_nx = ST_CBR_ISSUE;
            ST_CBR_ISSUE:  state_nx = ST_CBR_HOLD;
            ST_CBR_HOLD:
                if (t_expire) state_nx = cbr_all ? ST_MRS_ISSUE : ST_CBR_ISSUE;
            ST_MRS_ISSUE:  state_nx = ST_MRS_HOLD;
            ST_MRS_HOLD:   if (t_expire) state_nx = ST_NORM_ISSUE;
            ST_NORM_ISSUE: state_nx = ST_NORM_HOLD;
            ST_NORM_HOLD:  if (t_expire) state_nx = ST_PROBE_WR;
            ST_PROBE_WR:   state_nx = ST_PROBE_RD;
            ST_PROBE_RD:   state_nx = scan_found ? ST_NOP_ISSUE : ST_REF_ON;
            ST_REF_ON:     state_nx = ST_READY;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Row pointer follows the scanner whenever a new row is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row <= '0;
        end else if (state_nx == ST_NOP_ISSUE && state != ST_NOP_ISSUE) begin
            cur_row <= scan_idx;
        end
    end

    // Outputs, decoded from the state.
    always_comb begin
        in_row       = 1'b0;
        cmd_code     = CMD_NOP;
        cmd_strobe   = 1'b0;
        mrs_addr     = '0;
        probe_wr     = 1'b0;
        probe_rd     = 1'b0;
        probe_data   = '0;
        refresh_mode = REF_MODE_OFF;
        init_done    = 1'b0;
        unique case (state)
            ST_IDLE, ST_SETTLE: ;
            ST_NOP_ISSUE, ST_NOP_HOLD: begin
                in_row     = 1'b1;
                cmd_code   = CMD_NOP;
                cmd_strobe = (state == ST_NOP_ISSUE);
            end
            ST_PRE_ISSUE, ST_PRE_HOLD: begin
                in_row     = 1'b1;
                cmd_code   = CMD_PRECHARGE;
                cmd_strobe = (state == ST_PRE_ISSUE);
            end
            ST_CBR_ISSUE, ST_CBR_HOLD: begin
                in_row     = 1'b1;
                cmd_code   = CMD_AUTO_REF;
                cmd_strobe = (state == ST_CBR_ISSUE);
            end
            ST_MRS_ISSUE, ST_MRS_HOLD: begin
                in_row     = 1'b1;
                cmd_code   = CMD_MODE_SET;
                cmd_strobe = (state == ST_MRS_ISSUE);
                mrs_addr   = MRS_VALUE;
            end
            ST_NORM_ISSUE, ST_NORM_HOLD: begin
                in_row     = 1'b1;
                cmd_code   = CMD_NORMAL;
                cmd_strobe = (state == ST_NORM_ISSUE);
            end
            ST_PROBE_WR: begin
                in_row     = 1'b1;
                cmd_code   = CMD_NORMAL;
                probe_wr   = 1'b1;
                probe_data = PROBE_PATTERN;
            end
            ST_PROBE_RD: begin
                in_row     = 1'b1;
                cmd_code   = CMD_NORMAL;
                probe_rd   = 1'b1;
            end
            ST_REF_ON: begin
                cmd_code     = CMD_NORMAL;
                refresh_mode = REF_MODE_ON;
            end
            ST_READY: begin
                cmd_code     = CMD_NORMAL;
                refresh_mode = REF_MODE_ON;
                init_done    = 1'b1;
            end
            default: ;
        endcase
    end

    assign row_sel  = in_row ? (ROWS'(1) << cur_row) : '0;
    assign row_base = in_row ? base_of_cur : '0;
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int            ROWS          = 4,
    parameter int            BW            = 8,
    parameter int            AW            = 13,
    parameter int            DW            = 32,
    parameter logic [AW-1:0] MRS_VALUE     = 13'h1D0,
    parameter logic [DW-1:0] PROBE_PATTERN = 32'h55AA55AA
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [2:0]         cmd_code,
    input logic               cmd_strobe,
    input logic [ROWS-1:0]    row_sel,
    input logic [AW-1:0]      mrs_addr,
    input logic               probe_wr,
    input logic               probe_rd,
    input logic [DW-1:0]      probe_data,
    input logic [2:0]         refresh_mode,
    input logic               init_done
);
    assert_no_selfref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code != 3'd0);

    assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    assert_strobe_has_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (row_sel != '0));

    assert_issue_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    assert_mode_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_code == 3'd3) |-> (mrs_addr == MRS_VALUE));

    assert_probe_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
        probe_wr |-> (probe_data == PROBE_PATTERN && cmd_code == 3'd7));

    assert_probe_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        probe_wr |=> (probe_rd && !probe_wr));

    assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(refresh_mode) == 3'd1));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !start) |=> init_done);
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .ROWS(ROWS), .BW(BW), .AW(AW), .DW(DW),
    .MRS_VALUE(MRS_VALUE), .PROBE_PATTERN(PROBE_PATTERN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
    .cmd_strobe(cmd_strobe), .row_sel(row_sel), .mrs_addr(mrs_addr),
    .probe_wr(probe_wr), .probe_rd(probe_rd), .probe_data(probe_data),
    .refresh_mode(refresh_mode), .init_done(init_done)
);

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;
    localparam int ROWS = 4;
    localparam int BW   = 8;
    localparam int AW   = 13;
    localparam int DW   = 32;
    localparam int MAXE = 64;
    localparam int CYCLE_LIMIT = 150000;
    // Event kinds: command codes 1..7, 8 probe write, 9 probe read,
    // 10 refresh enabled, 11 done rise.
    localparam int K_PWR = 8, K_PRD = 9, K_REF = 10, K_DONE = 11;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               tick_us = 1'b0;
    logic [ROWS*BW-1:0] row_bound;
    logic [2:0]         cmd_code;
    logic               cmd_strobe;
    logic [ROWS-1:0]    row_sel;
    logic [BW-1:0]      row_base;
    logic [AW-1:0]      mrs_addr;
    logic               probe_wr, probe_rd;
    logic [DW-1:0]      probe_data;
    logic [2:0]         refresh_mode;
    logic               init_done;

    sdram_pwrup_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tick_us(tick_us),
        .row_bound(row_bound), .cmd_code(cmd_code), .cmd_strobe(cmd_strobe),
        .row_sel(row_sel), .row_base(row_base), .mrs_addr(mrs_addr),
        .probe_wr(probe_wr), .probe_rd(probe_rd), .probe_data(probe_data),
        .refresh_mode(refresh_mode), .init_done(init_done)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit wd_hit = 1'b0;
    int tick_pct = 100;

    logic [BW-1:0] bnd [ROWS];
    int exp_base [ROWS];
    always_comb for (int i = 0; i < ROWS; i++) row_bound[i*BW +: BW] = bnd[i];

    int exp_kind [MAXE], exp_row [MAXE], exp_gap [MAXE];
    int act_kind [MAXE], act_row [MAXE], act_gap [MAXE];
    int n_exp = 0, act_n = 0, pend = 0;
    bit running = 1'b0;
    int tickcnt = 0;
    logic prev_ref = 1'b0, prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int wait_after(input int k);
        case (k)
            1: return 200;
            2: return 1;
            6: return 1;
            3: return 2;
            7: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic void push(input int k, input int r);
        if (n_exp < MAXE) begin
            exp_kind[n_exp] = k; exp_row[n_exp] = r; exp_gap[n_exp] = pend;
        end
        n_exp++;
        pend = wait_after(k);
    endfunction

    function automatic void build_expected();
        int prev;
        n_exp = 0; pend = 200; prev = 0;
        for (int i = 0; i < ROWS; i++) begin
            exp_base[i] = prev;
            if (int'(bnd[i]) > prev) begin
                push(1, i); push(2, i);
                for (int c = 0; c < 8; c++) push(6, i);
                push(3, i); push(7, i); push(K_PWR, i); push(K_PRD, i);
            end
            prev = int'(bnd[i]);
        end
        push(K_REF, 7); push(K_DONE, 7);
    endfunction

    task automatic record(input int k);
        int r;
        r = 7;
        for (int i = 0; i < ROWS; i++) if (row_sel[i]) r = i;
        if (act_n < MAXE) begin
            act_kind[act_n] = k; act_row[act_n] = r; act_gap[act_n] = tickcnt;
        end
        act_n++;
        tickcnt = 0;
        if (r != 7) chk(int'(row_base) == exp_base[r], "R4 row_base", row_base, exp_base[r]);
        if (k == 3) chk(mrs_addr == 13'h1D0, "R6 mrs_addr", mrs_addr, 13'h1D0);
        if (k == K_PWR) begin
            chk(probe_data == 32'h55AA55AA, "R7 probe_data", probe_data, 32'h55AA55AA);
            chk(cmd_code == 3'd7, "R7 cmd during probe", cmd_code, 7);
        end
        if (k < K_PWR) chk(cmd_code != 3'd0, "R2 no self-refresh code", cmd_code, 1);
    endtask

    // Tick driver: inputs change shortly after the rising edge.
    always @(posedge clk) begin
        #2;
        tick_us <= (($urandom % 100) < tick_pct);
    end

    // Monitor: samples outputs and inputs in mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (cyc > CYCLE_LIMIT) wd_hit = 1'b1;
        if (rst_n) begin
            if (start && !running) begin
                running = 1'b1;
                tickcnt = 0;
            end else if (cmd_strobe) begin
                record(int'(cmd_code));
            end else if (probe_wr) begin
                record(K_PWR);
            end else if (probe_rd) begin
                record(K_PRD);
            end else if (refresh_mode != 3'd0 && prev_ref == 1'b0) begin
                chk(refresh_mode == 3'd1, "R8 refresh mode", refresh_mode, 1);
                record(K_REF);
            end else if (init_done && !prev_done) begin
                record(K_DONE);
                running = 1'b0;
            end else if (!start) begin
                tickcnt += int'(tick_us);
            end else begin
                tickcnt += int'(tick_us);
            end
            prev_ref  = (refresh_mode != 3'd0);
            prev_done = init_done;
        end
    end

    task automatic run_scenario(input bit inject, input int pct);
        int lim;
        tick_pct = pct;
        build_expected();
        act_n = 0;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        @(negedge clk); #1;
        chk(init_done == 1'b0, "R11 done cleared on restart", init_done, 0);
        chk(refresh_mode == 3'd0, "R11 refresh cleared on restart", refresh_mode, 0);
        while (running && !wd_hit) begin
            @(posedge clk); #2;
            if (inject && running && (act_n < n_exp - 4) && ($urandom % 40 == 0)) begin
                start = 1'b1;
                @(posedge clk); #2 start = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(init_done == 1'b1, "R8 done holds", init_done, 1);
        chk(refresh_mode == 3'd1, "R8 refresh holds", refresh_mode, 1);
        if (inject) chk(act_n == n_exp, "R9 stream unaffected by start", act_n, n_exp);
        else        chk(act_n == n_exp, "R5 event count", act_n, n_exp);
        if (n_exp == 2) chk(act_kind[0] == K_REF, "R10 refresh on empty set", act_kind[0], K_REF);
        lim = (act_n < n_exp) ? act_n : n_exp;
        if (lim > MAXE) lim = MAXE;
        for (int i = 0; i < lim; i++) begin
            chk(act_kind[i] == exp_kind[i], "R2 command order", act_kind[i], exp_kind[i]);
            chk(act_row[i] == exp_row[i], "R4 row visited", act_row[i], exp_row[i]);
            chk(act_gap[i] == exp_gap[i], (i == 0) ? "R3 settle ticks" : "R5 tick wait",
                act_gap[i], exp_gap[i]);
        end
    endtask

    task automatic set_bounds(input int a, input int b, input int c, input int d);
        bnd[0] = BW'(a); bnd[1] = BW'(b); bnd[2] = BW'(c); bnd[3] = BW'(d);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        set_bounds(0, 0, 0, 0);
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cmd_code == 3'd1, "R1 reset cmd", cmd_code, 1);
        chk({cmd_strobe, probe_wr, probe_rd, init_done} == 4'b0, "R1 reset strobes",
            {cmd_strobe, probe_wr, probe_rd, init_done}, 0);
        chk(row_sel == '0 && row_base == '0 && mrs_addr == '0, "R1 reset row outputs",
            row_sel, 0);
        chk(probe_data == '0 && refresh_mode == 3'd0, "R1 reset data/refresh", refresh_mode, 0);

        set_bounds(2, 4, 6, 8);         run_scenario(1'b0, 100);
        set_bounds(0, 0, 0, 0);         run_scenario(1'b1, 60);   // R10
        set_bounds(0, 3, 3, 7);         run_scenario(1'b1, 50);
        set_bounds(5, 3, 8, 8);         run_scenario(1'b1, 70);
        set_bounds(255, 255, 255, 255); run_scenario(1'b0, 80);
        set_bounds(0, 0, 0, 9);         run_scenario(1'b1, 100);
        for (int n = 0; n < 4 && !wd_hit; n++) begin
            set_bounds($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
            run_scenario(1'b1, 40 + ($urandom % 61));
        end

        if (wd_hit) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, CYCLE_LIMIT);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule